// File: doc/BRIEF.md
# ADC Result Sequencer Model

A synthesizable bus-functional model of the digital side of a multi-channel simultaneous-sampling converter. It stands in for the converter when a host controller is under test. It does not convert anything. Each channel takes its result from a preset input, and that value is captured for all channels together on the rising edge of the convert-start strobe.

After the sampling instant the model counts rising edges of an externally supplied conversion clock. The first result becomes available on the 13th edge, and each further channel follows three edges after the one before. The end-of-conversion strobe pulses low for each result. End-of-last-conversion goes low with the result of the last requested channel. The host reads results in channel order by pulling chip-select and read low. The model drives the data bus only during that window.

Three sticky flags report host protocol errors:
- the first conversion clock arrives too late after sampling;
- convert-start falls too soon after bus activity;
- a read is made while no unread result is available.

All inputs are sampled on the system clock `clk_i`.

Top module: `adc_seq_bfm`

## Requirements
- R1: After reset, `eoc_no` and `eolc_no` are high, `data_oe_o` and all three error flags are low, and `data_o` is zero.
- R2: A rising edge on `convst_ni` captures the preset words of all channels at once. Channel g is taken from `preset_i[g*DW +: DW]`. Preset changes made later do not alter the words that are read.
- R3: `eoc_no` stays high through the first 12 detected rising edges of `conv_clk_i` after the sampling instant, and goes low on the 13th.
- R4: Result k (counting from 0) becomes available on conversion clock edge 13+3k. An unread result's `eoc_no` pulse ends on the next conversion clock edge.
- R5: `eolc_no` goes low together with the `eoc_no` of result number `num_ch_i` (valid range 1..NCH), and not earlier. With one channel it falls on edge 13.
- R6: A read strobe is a falling edge of `rd_ni` while `cs_ni` is low. Each strobe that finds an unread result loads the next channel in ascending order and returns `eoc_no` high.
- R7: `data_oe_o` is high only while `cs_ni` and `rd_ni` are both low. `data_o` is zero outside that window, and `rd_ni` toggling with `cs_ni` high consumes nothing.
- R8: A read strobe with no unread result leaves the output word unchanged and sets `early_rd_err_o`.
- R9: A falling edge of `convst_ni` aborts a sequence in progress. `eoc_no` and `eolc_no` return high, and the next sequence again needs 13 conversion clock edges for its first result.
- R10: `late_clk_err_o` is set when no conversion clock edge has been detected within LATE_CYC system cycles after the sampling instant.
- R11: `quiet_err_o` is set when `convst_ni` falls fewer than QUIET_CYC idle cycles after the last cycle with both `cs_ni` and `rd_ni` low.
- R12: All error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| num_ch_i | input | $clog2(NCH+1) | Number of channels converted per sequence (1..NCH) |
| preset_i | input | NCH*DW | Per-channel result words, channel 0 in the low bits |
| convst_ni | input | 1 | Convert-start: low acquires, rising edge samples |
| conv_clk_i | input | 1 | External conversion clock |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| data_o | output | DW | Read data, zero when not driven |
| data_oe_o | output | 1 | Bus drive enable |
| eoc_no | output | 1 | End of conversion, active low |
| eolc_no | output | 1 | End of last conversion, active low |
| late_clk_err_o | output | 1 | First conversion clock late |
| quiet_err_o | output | 1 | Convert-start fell during bus quiet window |
| early_rd_err_o | output | 1 | Read with no result available |

## Verification
The embedded properties assume that every input is synchronous to `clk_i`. They also assume that `num_ch_i` is in 1..NCH and is held constant during a sequence. The stimulus drives all inputs on the falling clock edge. It sets `num_ch_i` only while reset is asserted. Each conversion clock pulse is held high for one full system cycle and low for another. This keeps every edge visible to the edge detectors. It also means the counted edges match the pulses issued by the bench.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned FIRST_EDGE_DEF = 13;
  localparam int unsigned NEXT_EDGE_DEF  = 3;

  typedef enum logic [1:0] {
    SIG_CONVST = 2'd0,
    SIG_RD     = 2'd1,
    SIG_CCLK   = 2'd2
  } sig_idx_e;
endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
  parameter int unsigned          N       = 3,
  parameter logic [N-1:0]         RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= RST_VAL[g];
      else         prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
    assign fall_o[g] = ~sig_i[g] & prev_q[g];
  end
endmodule

// File: rtl/adc_conv_sched.sv
module adc_conv_sched #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned FIRST = 13,
  parameter int unsigned STEP  = 3,
  localparam int unsigned CW   = $clog2(NCH + 1),
  localparam int unsigned KW   = $clog2(FIRST + STEP * NCH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] num_ch_i,
  input  logic          start_rise_i,
  input  logic          start_fall_i,
  input  logic          cclk_rise_i,
  input  logic          consume_i,
  output logic [CW-1:0] avail_o,
  output logic          first_wait_o,
  output logic          eoc_no,
  output logic          eolc_no
);
  logic          active_q;
  logic [KW-1:0] cnt_q, due_q, cnt_nx;
  logic [CW-1:0] avail_q, avail_nx;

  assign cnt_nx   = cnt_q + 1'b1;
  assign avail_nx = avail_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      due_q    <= KW'(FIRST);
      avail_q  <= '0;
      eoc_no   <= 1'b1;
      eolc_no  <= 1'b1;
    end else if (start_fall_i || start_rise_i) begin
      // fall aborts, rise samples and starts counting
      active_q <= start_rise_i;
      cnt_q    <= '0;
      due_q    <= KW'(FIRST);
      avail_q  <= '0;
      eoc_no   <= 1'b1;
      eolc_no  <= 1'b1;
    end else if (active_q && cclk_rise_i) begin
      cnt_q <= cnt_nx;
      if (cnt_nx == due_q) begin
        avail_q <= avail_nx;
        due_q   <= due_q + KW'(STEP);
        eoc_no  <= 1'b0;
        if (avail_nx == num_ch_i) begin
          eolc_no  <= 1'b0;
          active_q <= 1'b0;
        end
      end else begin
        eoc_no <= 1'b1;
      end
    end else if (consume_i) begin
      eoc_no <= 1'b1;
    end
  end

  assign avail_o      = avail_q;
  assign first_wait_o = active_q && (cnt_q == '0);

  // R3
  eoc_on_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eoc_no) |-> $past(cclk_rise_i));
  // R5
  eolc_with_eoc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eolc_no) |-> $fell(eoc_no));
  // R9
  abort_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_fall_i |=> (eoc_no && eolc_no && avail_o == '0));
endmodule

// File: rtl/adc_read_port.sv
module adc_read_port #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12,
  localparam int unsigned CW = $clog2(NCH + 1),
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH*DW-1:0] preset_i,
  input  logic              start_rise_i,
  input  logic              start_fall_i,
  input  logic              rd_fall_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic [CW-1:0]     avail_i,
  output logic              consume_o,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic              early_o
);
  logic [NCH*DW-1:0] smp_q;
  logic [CW-1:0]     rd_idx_q;
  logic [DW-1:0]     data_q;
  logic              strobe, early_strobe, early_q;
  logic [IW-1:0]     sel;

  assign strobe       = rd_fall_i && !cs_ni;
  assign consume_o    = strobe && (rd_idx_q < avail_i);
  assign early_strobe = strobe && !(rd_idx_q < avail_i);
  assign sel          = rd_idx_q[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q    <= '0;
      rd_idx_q <= '0;
      data_q   <= '0;
      early_q  <= 1'b0;
    end else begin
      if (start_rise_i) smp_q <= preset_i;
      if (start_rise_i || start_fall_i) begin
        rd_idx_q <= '0;
      end else if (consume_o) begin
        data_q   <= smp_q[sel*DW +: DW];
        rd_idx_q <= rd_idx_q + 1'b1;
      end
      if (early_strobe) early_q <= 1'b1;
    end
  end

  assign data_oe_o = !cs_ni && !rd_ni;
  assign data_o    = data_oe_o ? data_q : '0;
  assign early_o   = early_q;

  // R6
  rd_idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_q <= avail_i);
  // R8
  early_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_strobe |=> ($stable(data_q) && early_q));
  // R7
  bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> (data_o == '0));
endmodule

// File: rtl/adc_proto_mon.sv
module adc_proto_mon #(
  parameter int unsigned LATE_CYC  = 1000,
  parameter int unsigned QUIET_CYC = 5,
  localparam int unsigned GW = $clog2(LATE_CYC + 1),
  localparam int unsigned QW = $clog2(QUIET_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_rise_i,
  input  logic start_fall_i,
  input  logic first_wait_i,
  input  logic cclk_rise_i,
  input  logic bus_act_i,
  output logic late_o,
  output logic quiet_o
);
  logic [GW-1:0] gap_q;
  logic [QW-1:0] idle_q;
  logic          late_q, quiet_q;
  logic          gap_top;

  assign gap_top = (gap_q == GW'(LATE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      idle_q  <= QW'(QUIET_CYC);
      late_q  <= 1'b0;
      quiet_q <= 1'b0;
    end else begin
      if (start_rise_i)                gap_q <= '0;
      else if (first_wait_i && !gap_top) gap_q <= gap_q + 1'b1;
      if (first_wait_i && !cclk_rise_i && gap_top) late_q <= 1'b1;

      if (bus_act_i)                          idle_q <= '0;
      else if (idle_q != QW'(QUIET_CYC))      idle_q <= idle_q + 1'b1;
      if (start_fall_i && idle_q < QW'(QUIET_CYC)) quiet_q <= 1'b1;
    end
  end

  assign late_o  = late_q;
  assign quiet_o = quiet_q;

  // R12
  late_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_o |=> late_o);
  // R12
  quiet_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_o |=> quiet_o);
  // R11
  quiet_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(quiet_o) |-> $past(start_fall_i));
endmodule

// File: rtl/adc_seq_bfm.sv
module adc_seq_bfm
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned DW        = 12,
  parameter int unsigned FIRST     = FIRST_EDGE_DEF,
  parameter int unsigned STEP      = NEXT_EDGE_DEF,
  parameter int unsigned LATE_CYC  = 1000,
  parameter int unsigned QUIET_CYC = 5,
  localparam int unsigned CW       = $clog2(NCH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     num_ch_i,
  input  logic [NCH*DW-1:0] preset_i,
  input  logic              convst_ni,
  input  logic              conv_clk_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic              eoc_no,
  output logic              eolc_no,
  output logic              late_clk_err_o,
  output logic              quiet_err_o,
  output logic              early_rd_err_o
);
  logic [2:0]    sig, rise, fall;
  logic [CW-1:0] avail;
  logic          consume, first_wait;

  assign sig[SIG_CONVST] = convst_ni;
  assign sig[SIG_RD]     = rd_ni;
  assign sig[SIG_CCLK]   = conv_clk_i;

  adc_edge_det #(.N(3), .RST_VAL(3'b011)) u_edge (
    .clk_i, .rst_ni, .sig_i(sig), .rise_o(rise), .fall_o(fall)
  );

  adc_conv_sched #(.NCH(NCH), .FIRST(FIRST), .STEP(STEP)) u_sched (
    .clk_i, .rst_ni, .num_ch_i,
    .start_rise_i(rise[SIG_CONVST]), .start_fall_i(fall[SIG_CONVST]),
    .cclk_rise_i(rise[SIG_CCLK]), .consume_i(consume),
    .avail_o(avail), .first_wait_o(first_wait), .eoc_no, .eolc_no
  );

  adc_read_port #(.NCH(NCH), .DW(DW)) u_rd (
    .clk_i, .rst_ni, .preset_i,
    .start_rise_i(rise[SIG_CONVST]), .start_fall_i(fall[SIG_CONVST]),
    .rd_fall_i(fall[SIG_RD]), .cs_ni, .rd_ni, .avail_i(avail),
    .consume_o(consume), .data_o, .data_oe_o, .early_o(early_rd_err_o)
  );

  adc_proto_mon #(.LATE_CYC(LATE_CYC), .QUIET_CYC(QUIET_CYC)) u_mon (
    .clk_i, .rst_ni,
    .start_rise_i(rise[SIG_CONVST]), .start_fall_i(fall[SIG_CONVST]),
    .first_wait_i(first_wait), .cclk_rise_i(rise[SIG_CCLK]),
    .bus_act_i(!cs_ni && !rd_ni),
    .late_o(late_clk_err_o), .quiet_o(quiet_err_o)
  );
endmodule

// File: tb/adc_seq_bfm_bench.sv
module adc_seq_bfm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW = 12;
  localparam int CW = $clog2(NCH + 1);
  localparam int LATE = 40;
  localparam int QUIET = 5;
  localparam logic [NCH*DW-1:0] SET_A = {12'h3C4, 12'h2B7, 12'h1A9, 12'h0A5};
  localparam logic [NCH*DW-1:0] SET_B = {12'hF0F, 12'hE1E, 12'hD2D, 12'hC3C};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] num_ch = 3'(NCH);
  logic [NCH*DW-1:0] preset = SET_A;
  logic convst_n = 1'b1, cclk = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
  logic [DW-1:0] data;
  logic oe, eoc_n, eolc_n, late_err, quiet_err, early_err;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_seq_bfm #(.NCH(NCH), .DW(DW), .LATE_CYC(LATE), .QUIET_CYC(QUIET)) u_adc_seq_bfm (
    .clk_i(clk), .rst_ni(rst_n), .num_ch_i(num_ch), .preset_i(preset),
    .convst_ni(convst_n), .conv_clk_i(cclk), .cs_ni(cs_n), .rd_ni(rd_n),
    .data_o(data), .data_oe_o(oe), .eoc_no(eoc_n), .eolc_no(eolc_n),
    .late_clk_err_o(late_err), .quiet_err_o(quiet_err), .early_rd_err_o(early_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic do_reset(input logic [CW-1:0] n);
    @(negedge clk);
    rst_n = 1'b0; convst_n = 1'b1; cclk = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
    num_ch = n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // gap: idle negedges before convst falls; returns one negedge after the rise
  task automatic start_conv(input int gap);
    repeat (gap) @(negedge clk);
    convst_n = 1'b0;
    repeat (3) @(negedge clk);
    convst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cclk = 1'b1;
      @(negedge clk); cclk = 1'b0;
    end
  endtask

  task automatic do_read(output logic [DW-1:0] word);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    chk("R7 oe during read", 32'(oe), 32'd1);
    word = data;
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset(3'(NCH));
    chk("R1 eoc", 32'(eoc_n), 32'd1);
    chk("R1 eolc", 32'(eolc_n), 32'd1);
    chk("R1 oe", 32'(oe), 32'd0);
    chk("R1 data", 32'(data), 32'd0);
    chk("R1 flags", 32'({late_err, quiet_err, early_err}), 32'd0);
  endtask

  task automatic test_sequence();
    logic [DW-1:0] w;
    do_reset(3'(NCH));
    preset = SET_A;
    start_conv(10);
    preset = SET_B;
    pulse(12);
    chk("R3 eoc high after 12", 32'(eoc_n), 32'd1);
    pulse(1);
    chk("R3 eoc low at 13", 32'(eoc_n), 32'd0);
    chk("R5 eolc high at 13", 32'(eolc_n), 32'd1);
    pulse(1);
    chk("R4 eoc ends at next edge", 32'(eoc_n), 32'd1);
    pulse(1);
    chk("R4 eoc high at 15", 32'(eoc_n), 32'd1);
    pulse(1);
    chk("R4 eoc low at 16", 32'(eoc_n), 32'd0);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk);
    chk("R7 oe with cs high", 32'(oe), 32'd0);
    chk("R7 data with cs high", 32'(data), 32'd0);
    rd_n = 1'b1;
    @(negedge clk);
    chk("R7 no consume with cs high", 32'(eoc_n), 32'd0);
    do_read(w);
    chk("R6 ch0 word", 32'(w), 32'(SET_A[0*DW +: DW]));
    chk("R6 eoc high after read", 32'(eoc_n), 32'd1);
    chk("R7 oe after read", 32'(oe), 32'd0);
    pulse(3);
    chk("R4 eoc low at 19", 32'(eoc_n), 32'd0);
    chk("R5 eolc high at 19", 32'(eolc_n), 32'd1);
    pulse(3);
    chk("R5 eolc low at 22", 32'(eolc_n), 32'd0);
    chk("R5 eoc low at 22", 32'(eoc_n), 32'd0);
    do_read(w);
    chk("R2 ch1 word", 32'(w), 32'(SET_A[1*DW +: DW]));
    do_read(w);
    chk("R6 ch2 word", 32'(w), 32'(SET_A[2*DW +: DW]));
    do_read(w);
    chk("R2 ch3 word", 32'(w), 32'(SET_A[3*DW +: DW]));
    chk("R8 no early yet", 32'(early_err), 32'd0);
    do_read(w);
    chk("R8 word held", 32'(w), 32'(SET_A[3*DW +: DW]));
    chk("R8 early flag", 32'(early_err), 32'd1);
  endtask

  task automatic test_early();
    logic [DW-1:0] w;
    do_reset(3'd2);
    preset = SET_A;
    start_conv(10);
    do_read(w);
    chk("R8 early word", 32'(w), 32'd0);
    chk("R8 early flag", 32'(early_err), 32'd1);
    pulse(13);
    do_read(w);
    chk("R6 word after early", 32'(w), 32'(SET_A[0*DW +: DW]));
    chk("R12 early sticky", 32'(early_err), 32'd1);
  endtask

  task automatic test_abort();
    logic [DW-1:0] w;
    do_reset(3'd2);
    preset = SET_A;
    start_conv(10);
    pulse(13);
    chk("R9 eoc low before abort", 32'(eoc_n), 32'd0);
    preset = SET_B;
    repeat (10) @(negedge clk);
    convst_n = 1'b0;
    @(negedge clk);
    chk("R9 eoc high on abort", 32'(eoc_n), 32'd1);
    chk("R9 eolc high on abort", 32'(eolc_n), 32'd1);
    repeat (2) @(negedge clk);
    convst_n = 1'b1;
    @(negedge clk);
    pulse(12);
    chk("R9 restart eoc high at 12", 32'(eoc_n), 32'd1);
    pulse(1);
    chk("R9 restart eoc low at 13", 32'(eoc_n), 32'd0);
    do_read(w);
    chk("R9 new sample word", 32'(w), 32'(SET_B[0*DW +: DW]));
    chk("R11 no quiet err", 32'(quiet_err), 32'd0);
  endtask

  task automatic test_one_ch();
    do_reset(3'd1);
    start_conv(10);
    pulse(12);
    chk("R5 one ch eolc high at 12", 32'(eolc_n), 32'd1);
    pulse(1);
    chk("R5 one ch eolc low at 13", 32'(eolc_n), 32'd0);
  endtask

  task automatic test_late();
    do_reset(3'(NCH));
    start_conv(10);
    repeat (LATE - 2) @(negedge clk);
    pulse(1);
    chk("R10 on-time clock", 32'(late_err), 32'd0);
    do_reset(3'(NCH));
    start_conv(10);
    repeat (LATE - 1) @(negedge clk);
    pulse(1);
    chk("R10 late clock", 32'(late_err), 32'd1);
  endtask

  task automatic test_quiet();
    logic [DW-1:0] w;
    do_reset(3'(NCH));
    do_read(w);
    start_conv(QUIET - 1);
    chk("R11 no err at limit", 32'(quiet_err), 32'd0);
    do_reset(3'(NCH));
    do_read(w);
    start_conv(QUIET - 2);
    chk("R11 err when too soon", 32'(quiet_err), 32'd1);
    start_conv(10);
    pulse(13);
    chk("R12 quiet sticky", 32'(quiet_err), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    test_reset();
    test_sequence();
    test_early();
    test_abort();
    test_one_ch();
    test_late();
    test_quiet();
    summary();
    $finish;
  end
endmodule